// File: doc/BRIEF.md
# Partial-Access General Register File

This block holds four 64-bit general registers. A client can read or write each one as the full 64-bit word, as its low 32 bits, as its low 16 bits, or as either of the two bytes in that low half-word. It has one write port and two independent read ports. Every port carries a register index, an access size and a high-byte select. A narrow write changes only its own slice, and every other bit of the wide register keeps its value. A narrow read returns its slice zero-extended to 64 bits.

Three groups of plain storage sit beside the general registers:
- Six 16-bit segment registers. Each one loads only by copying the low half-word of a named general register.
- Four 64-bit index/pointer registers, written as whole words.
- An instruction pointer. It can be read at all times and loads only through its own load strobe. The general write port can never reach it.

A control module decodes each write request into a small set of strobes. A datapath module holds the storage and builds the read views.

Top module: `part_regfile`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears every general, segment, pointer and instruction-pointer register to zero.
- R2: A write with size code 3 (64 bits) replaces the whole target register. A later 64-bit read returns that value.
- R3: A write with size code 2 (32 bits) replaces bits 31:0 and keeps bits 63:32.
- R4: A write with size code 1 (16 bits) replaces bits 15:0 and keeps every other bit.
- R5: A write with size code 0 (8 bits) and the high select low replaces bits 7:0 from `wrData[7:0]` and keeps every other bit.
- R6: A write with size code 0 and the high select high places `wrData[7:0]` into bits 15:8 and keeps every other bit. A read with size code 0 and the high select high returns bits 15:8 in `rdData[7:0]`.
- R7: Reads are combinational. A read of size 0, 1 or 2 returns the selected slice zero-extended to 64 bits.
- R8: If the high select is combined with any size code other than 0:
  - a write raises `wrIllegal` in that same cycle and changes no register;
  - a read in that combination returns zero.
- R9: The two read ports select independently. A write takes effect at the rising edge, so a read of the target register in the write's own cycle still shows the old value.
- R10: When `segWrEn` is high, segment register `segWrIdx` (0 to 5) loads bits 15:0 of general register `segWrSrc`, using the value held before that edge. Index values 6 and 7 write nothing and read as zero.
- R11: When `ptrWrEn` is high, pointer register `ptrWrIdx` loads all 64 bits of `ptrWrData`.
- R12: The instruction pointer `ipOut` changes only on an edge where `ipLoad` is high, and then takes `ipNext`. General-register writes never change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wrEn | input | 1 | General write enable |
| wrIdx | input | 2 | General write register index |
| wrSize | input | 2 | Write size code: 0=8, 1=16, 2=32, 3=64 bits |
| wrHigh | input | 1 | Write high-byte select |
| wrData | input | 64 | Write data, right-aligned |
| wrIllegal | output | 1 | Write request has an illegal size/high combination |
| rdAIdx | input | 2 | Read port A register index |
| rdASize | input | 2 | Read port A size code |
| rdAHigh | input | 1 | Read port A high-byte select |
| rdAData | output | 64 | Read port A data, zero-extended |
| rdBIdx | input | 2 | Read port B register index |
| rdBSize | input | 2 | Read port B size code |
| rdBHigh | input | 1 | Read port B high-byte select |
| rdBData | output | 64 | Read port B data, zero-extended |
| segWrEn | input | 1 | Segment load enable |
| segWrIdx | input | 3 | Segment register index |
| segWrSrc | input | 2 | General register supplying the segment value |
| segRdIdx | input | 3 | Segment read index |
| segRdData | output | 16 | Segment read data |
| ptrWrEn | input | 1 | Pointer register write enable |
| ptrWrIdx | input | 2 | Pointer register write index |
| ptrWrData | input | 64 | Pointer register write data |
| ptrRdIdx | input | 2 | Pointer register read index |
| ptrRdData | output | 64 | Pointer register read data |
| ipLoad | input | 1 | Instruction pointer load strobe |
| ipNext | input | 64 | Instruction pointer load value |
| ipOut | output | 64 | Instruction pointer value |

## Verification
The assertions assume that the size code and high select are driven to known values whenever `wrEn` is high. They also assume that reset is held for at least one edge before any access. The bench changes every input only on the falling edge. It keeps `wrEn` low except inside write tasks, and it applies reset before any scenario runs. Illegal combinations are presented deliberately, in one scenario only. Those cycles are checked for both the flag and an unchanged register.

// File: rtl/part_regfile_pkg.sv
package part_regfile_pkg;
  parameter int GPR_W     = 64;
  parameter int GPR_N     = 4;
  parameter int SEG_W     = 16;
  parameter int SEG_N     = 6;
  parameter int PTR_N     = 4;
  localparam int GPR_BYTES = GPR_W / 8;
  localparam int GPR_IDX_W = $clog2(GPR_N);

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_HALF  = 2'd1,
    SZ_DWORD = 2'd2,
    SZ_FULL  = 2'd3
  } accSize_t;

  typedef struct packed {
    logic [GPR_N-1:0]     gprWe;
    logic [GPR_BYTES-1:0] byteMask;
    logic                 highLane;
  } wrStrobe_t;
endpackage

// File: rtl/part_regfile_ctrl.sv
module part_regfile_ctrl
  import part_regfile_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wrEn,
  input  logic [GPR_IDX_W-1:0] wrIdx,
  input  logic [1:0]           wrSize,
  input  logic                 wrHigh,
  output wrStrobe_t            strobe,
  output logic                 wrIllegal
);
  logic badCombo;
  assign badCombo  = wrHigh && (accSize_t'(wrSize) != SZ_BYTE);
  assign wrIllegal = wrEn && badCombo;

  always_comb begin
    strobe = '0;
    strobe.highLane = wrHigh;
    unique case (accSize_t'(wrSize))
      SZ_BYTE:  strobe.byteMask = wrHigh ? GPR_BYTES'(2) : GPR_BYTES'(1);
      SZ_HALF:  strobe.byteMask = GPR_BYTES'(3);
      SZ_DWORD: strobe.byteMask = GPR_BYTES'(15);
      default:  strobe.byteMask = '1;
    endcase
    if (wrEn && !badCombo) strobe.gprWe[wrIdx] = 1'b1;
  end

  assert_illegal_no_write_R8: assert property (@(posedge clk) disable iff (rst)
    wrIllegal |-> (strobe.gprWe == '0));
  assert_single_target_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(strobe.gprWe));
  assert_legal_write_strobes_R9: assert property (@(posedge clk) disable iff (rst)
    (wrEn && !wrIllegal) |-> ($countones(strobe.gprWe) == 1));
endmodule

// File: rtl/part_regfile_dp.sv
module part_regfile_dp
  import part_regfile_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  wrStrobe_t            strobe,
  input  logic [GPR_W-1:0]     wrData,
  input  logic [GPR_IDX_W-1:0] rdAIdx,
  input  logic [1:0]           rdASize,
  input  logic                 rdAHigh,
  output logic [GPR_W-1:0]     rdAData,
  input  logic [GPR_IDX_W-1:0] rdBIdx,
  input  logic [1:0]           rdBSize,
  input  logic                 rdBHigh,
  output logic [GPR_W-1:0]     rdBData,
  input  logic                 segWrEn,
  input  logic [2:0]           segWrIdx,
  input  logic [GPR_IDX_W-1:0] segWrSrc,
  input  logic [2:0]           segRdIdx,
  output logic [SEG_W-1:0]     segRdData,
  input  logic                 ptrWrEn,
  input  logic [1:0]           ptrWrIdx,
  input  logic [GPR_W-1:0]     ptrWrData,
  input  logic [1:0]           ptrRdIdx,
  output logic [GPR_W-1:0]     ptrRdData,
  input  logic                 ipLoad,
  input  logic [GPR_W-1:0]     ipNext,
  output logic [GPR_W-1:0]     ipOut
);
  logic [GPR_W-1:0] gpr [GPR_N];
  logic [SEG_W-1:0] seg [SEG_N];
  logic [GPR_W-1:0] ptr [PTR_N];
  logic [GPR_W-1:0] ipReg;

  logic [GPR_W-1:0] laneData;
  logic [GPR_W-1:0] bitMask;

  assign laneData = strobe.highLane ? {wrData[GPR_W-9:0], 8'h00} : wrData;

  for (genvar b = 0; b < GPR_BYTES; b++) begin : g_mask
    assign bitMask[b*8 +: 8] = {8{strobe.byteMask[b]}};
  end

  for (genvar i = 0; i < GPR_N; i++) begin : g_gpr
    always_ff @(posedge clk) begin
      if (rst)                  gpr[i] <= '0;
      else if (strobe.gprWe[i]) gpr[i] <= (gpr[i] & ~bitMask) | (laneData & bitMask);
    end
    assert_keep_upper_R3: assert property (@(posedge clk) disable iff (rst)
      (strobe.gprWe[i] && !strobe.byteMask[4]) |=> (gpr[i][GPR_W-1:32] == $past(gpr[i][GPR_W-1:32])));
    assert_keep_low_byte_R6: assert property (@(posedge clk) disable iff (rst)
      (strobe.gprWe[i] && !strobe.byteMask[0]) |=> (gpr[i][7:0] == $past(gpr[i][7:0])));
  end

  function automatic logic [GPR_W-1:0] viewOf(logic [GPR_W-1:0] word, logic [1:0] size, logic high);
    logic [GPR_W-1:0] v;
    v = '0;
    unique case (accSize_t'(size))
      SZ_BYTE:  v[7:0]  = high ? word[15:8] : word[7:0];
      SZ_HALF:  v[15:0] = high ? 16'h0 : word[15:0];
      SZ_DWORD: v[31:0] = high ? 32'h0 : word[31:0];
      default:  v       = high ? '0 : word;
    endcase
    return v;
  endfunction

  assign rdAData = viewOf(gpr[rdAIdx], rdASize, rdAHigh);
  assign rdBData = viewOf(gpr[rdBIdx], rdBSize, rdBHigh);

  for (genvar s = 0; s < SEG_N; s++) begin : g_seg
    always_ff @(posedge clk) begin
      if (rst)                                      seg[s] <= '0;
      else if (segWrEn && (int'(segWrIdx) == s))    seg[s] <= gpr[segWrSrc][SEG_W-1:0];
    end
  end
  assign segRdData = (int'(segRdIdx) < SEG_N) ? seg[segRdIdx] : '0;

  for (genvar p = 0; p < PTR_N; p++) begin : g_ptr
    always_ff @(posedge clk) begin
      if (rst)                                    ptr[p] <= '0;
      else if (ptrWrEn && (int'(ptrWrIdx) == p))  ptr[p] <= ptrWrData;
    end
  end
  assign ptrRdData = ptr[ptrRdIdx];

  always_ff @(posedge clk) begin
    if (rst)         ipReg <= '0;
    else if (ipLoad) ipReg <= ipNext;
  end
  assign ipOut = ipReg;

  assert_ip_hold_R12: assert property (@(posedge clk) disable iff (rst)
    !ipLoad |=> $stable(ipReg));
  assert_reset_clear_R1: assert property (@(posedge clk)
    $past(rst) |-> (ipReg == '0 && ptrRdData == '0 && segRdData == '0));
endmodule

// File: rtl/part_regfile.sv
module part_regfile
  import part_regfile_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        wrEn,
  input  logic [1:0]  wrIdx,
  input  logic [1:0]  wrSize,
  input  logic        wrHigh,
  input  logic [63:0] wrData,
  output logic        wrIllegal,
  input  logic [1:0]  rdAIdx,
  input  logic [1:0]  rdASize,
  input  logic        rdAHigh,
  output logic [63:0] rdAData,
  input  logic [1:0]  rdBIdx,
  input  logic [1:0]  rdBSize,
  input  logic        rdBHigh,
  output logic [63:0] rdBData,
  input  logic        segWrEn,
  input  logic [2:0]  segWrIdx,
  input  logic [1:0]  segWrSrc,
  input  logic [2:0]  segRdIdx,
  output logic [15:0] segRdData,
  input  logic        ptrWrEn,
  input  logic [1:0]  ptrWrIdx,
  input  logic [63:0] ptrWrData,
  input  logic [1:0]  ptrRdIdx,
  output logic [63:0] ptrRdData,
  input  logic        ipLoad,
  input  logic [63:0] ipNext,
  output logic [63:0] ipOut
);
  wrStrobe_t strobe;

  part_regfile_ctrl u_ctrl (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrIdx(wrIdx), .wrSize(wrSize),
    .wrHigh(wrHigh), .strobe(strobe), .wrIllegal(wrIllegal)
  );

  part_regfile_dp u_dp (
    .clk(clk), .rst(rst), .strobe(strobe), .wrData(wrData),
    .rdAIdx(rdAIdx), .rdASize(rdASize), .rdAHigh(rdAHigh), .rdAData(rdAData),
    .rdBIdx(rdBIdx), .rdBSize(rdBSize), .rdBHigh(rdBHigh), .rdBData(rdBData),
    .segWrEn(segWrEn), .segWrIdx(segWrIdx), .segWrSrc(segWrSrc),
    .segRdIdx(segRdIdx), .segRdData(segRdData),
    .ptrWrEn(ptrWrEn), .ptrWrIdx(ptrWrIdx), .ptrWrData(ptrWrData),
    .ptrRdIdx(ptrRdIdx), .ptrRdData(ptrRdData),
    .ipLoad(ipLoad), .ipNext(ipNext), .ipOut(ipOut)
  );
endmodule

// File: tb/part_regfile_tb.sv
module part_regfile_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst;
  logic wrEn; logic [1:0] wrIdx; logic [1:0] wrSize; logic wrHigh; logic [63:0] wrData;
  logic wrIllegal;
  logic [1:0] rdAIdx; logic [1:0] rdASize; logic rdAHigh; logic [63:0] rdAData;
  logic [1:0] rdBIdx; logic [1:0] rdBSize; logic rdBHigh; logic [63:0] rdBData;
  logic segWrEn; logic [2:0] segWrIdx; logic [1:0] segWrSrc; logic [2:0] segRdIdx; logic [15:0] segRdData;
  logic ptrWrEn; logic [1:0] ptrWrIdx; logic [63:0] ptrWrData; logic [1:0] ptrRdIdx; logic [63:0] ptrRdData;
  logic ipLoad; logic [63:0] ipNext; logic [63:0] ipOut;

  int nChecks = 0;
  int nFails  = 0;
  logic [63:0] mdl [4];

  always #(CLK_PERIOD/2) clk = ~clk;

  part_regfile u_dut (.*);

  task automatic check(string req, logic [63:0] got, logic [63:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, got, exp);
    end
  endtask

  task automatic gprWrite(int idx, int size, bit high, logic [63:0] data);
    logic [63:0] m;
    @(negedge clk);
    wrEn = 1'b1; wrIdx = 2'(idx); wrSize = 2'(size); wrHigh = high; wrData = data;
    @(posedge clk);
    @(negedge clk);
    wrEn = 1'b0;
    if (!(high && size != 0)) begin
      case (size)
        0: m = high ? 64'hFF00 : 64'hFF;
        1: m = 64'hFFFF;
        2: m = 64'hFFFF_FFFF;
        default: m = '1;
      endcase
      mdl[idx] = (mdl[idx] & ~m) | ((high ? {data[55:0], 8'h00} : data) & m);
    end
  endtask

  task automatic readA(int idx, int size, bit high, string req, logic [63:0] exp);
    rdAIdx = 2'(idx); rdASize = 2'(size); rdAHigh = high;
    #1 check(req, rdAData, exp);
  endtask

  task automatic tReset();
    rst = 1'b1;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 4; i++) begin
      mdl[i] = '0;
      readA(i, 3, 0, "R1 gpr", 64'h0);
    end
    ptrRdIdx = 2'd3; segRdIdx = 3'd5;
    #1 check("R1 ptr", ptrRdData, 0);
    check("R1 seg", 64'(segRdData), 0);
    check("R1 ip", ipOut, 0);
  endtask

  task automatic tFull();
    gprWrite(0, 3, 0, 64'h0123_4567_89AB_CDEF);
    readA(0, 3, 0, "R2 full", 64'h0123_4567_89AB_CDEF);
    gprWrite(2, 3, 0, 64'hFEDC_BA98_7654_3210);
    readA(2, 3, 0, "R2 full other", mdl[2]);
  endtask

  task automatic tDword();
    gprWrite(0, 2, 0, 64'hAAAA_AAAA_1111_2222);
    readA(0, 3, 0, "R3 upper kept", 64'h0123_4567_1111_2222);
    readA(0, 2, 0, "R7 dword zero-ext", 64'h1111_2222);
  endtask

  task automatic tHalf();
    gprWrite(0, 1, 0, 64'hFFFF_FFFF_FFFF_BEEF);
    readA(0, 3, 0, "R4 half merge", 64'h0123_4567_1111_BEEF);
    readA(0, 1, 0, "R7 half zero-ext", 64'hBEEF);
  endtask

  task automatic tLow();
    gprWrite(1, 3, 0, 64'h1111_1111_1111_1111);
    gprWrite(1, 0, 0, 64'hFFFF_FFFF_FFFF_FF5A);
    readA(1, 3, 0, "R5 low byte", 64'h1111_1111_1111_115A);
    readA(1, 0, 0, "R7 byte zero-ext", 64'h5A);
  endtask

  task automatic tHigh();
    gprWrite(1, 0, 1, 64'hFFFF_FFFF_FFFF_FFC3);
    readA(1, 3, 0, "R6 high byte write", 64'h1111_1111_1111_C35A);
    readA(1, 0, 1, "R6 high byte read", 64'hC3);
  endtask

  task automatic tIllegal();
    for (int sz = 1; sz < 4; sz++) begin
      @(negedge clk);
      wrEn = 1'b1; wrIdx = 2'd1; wrSize = 2'(sz); wrHigh = 1'b1; wrData = '1;
      #1 check("R8 flag", 64'(wrIllegal), 1);
      @(posedge clk); @(negedge clk);
      wrEn = 1'b0; wrHigh = 1'b0;
      readA(1, 3, 0, "R8 no write", 64'h1111_1111_1111_C35A);
      readA(1, sz, 1, "R8 read zero", 64'h0);
    end
    @(negedge clk);
    wrEn = 1'b1; wrSize = 2'd0; wrHigh = 1'b1;
    #1 check("R8 legal no flag", 64'(wrIllegal), 0);
    wrEn = 1'b0; wrHigh = 1'b0;
  endtask

  task automatic tPorts();
    @(negedge clk);
    rdBIdx = 2'd2; rdBSize = 2'd3; rdBHigh = 1'b0;
    rdAIdx = 2'd0; rdASize = 2'd3; rdAHigh = 1'b0;
    #1 check("R9 port B", rdBData, mdl[2]);
    check("R9 port A", rdAData, mdl[0]);
    wrEn = 1'b1; wrIdx = 2'd2; wrSize = 2'd3; wrHigh = 1'b0; wrData = 64'h5555_6666_7777_8888;
    #1 check("R9 old before edge", rdBData, mdl[2]);
    @(posedge clk); @(negedge clk);
    wrEn = 1'b0; mdl[2] = 64'h5555_6666_7777_8888;
    check("R9 new after edge", rdBData, mdl[2]);
  endtask

  task automatic tSeg();
    @(negedge clk);
    segWrEn = 1'b1; segWrIdx = 3'd4; segWrSrc = 2'd1;
    @(posedge clk); @(negedge clk);
    segWrEn = 1'b0; segRdIdx = 3'd4;
    #1 check("R10 seg load", 64'(segRdData), 64'hC35A);
    segWrEn = 1'b1; segWrIdx = 3'd6; segWrSrc = 2'd2;
    @(posedge clk); @(negedge clk);
    segWrEn = 1'b0; segRdIdx = 3'd6;
    #1 check("R10 idx6 reads zero", 64'(segRdData), 0);
    segRdIdx = 3'd4;
    #1 check("R10 idx6 no effect", 64'(segRdData), 64'hC35A);
  endtask

  task automatic tPtr();
    @(negedge clk);
    ptrWrEn = 1'b1; ptrWrIdx = 2'd2; ptrWrData = 64'hDEAD_BEEF_CAFE_F00D;
    @(posedge clk); @(negedge clk);
    ptrWrEn = 1'b0; ptrRdIdx = 2'd2;
    #1 check("R11 ptr", ptrRdData, 64'hDEAD_BEEF_CAFE_F00D);
    ptrRdIdx = 2'd1;
    #1 check("R11 other ptr", ptrRdData, 0);
  endtask

  task automatic tIp();
    gprWrite(3, 3, 0, 64'h1234);
    check("R12 ip untouched", ipOut, 0);
    @(negedge clk);
    ipLoad = 1'b1; ipNext = 64'h0000_0000_0040_1000;
    @(posedge clk); @(negedge clk);
    ipLoad = 1'b0; ipNext = 64'h9;
    check("R12 ip load", ipOut, 64'h0040_1000);
    @(posedge clk); @(negedge clk);
    check("R12 ip hold", ipOut, 64'h0040_1000);
  endtask

  initial begin
    rst = 1'b1; wrEn = 0; wrIdx = 0; wrSize = 0; wrHigh = 0; wrData = 0;
    rdAIdx = 0; rdASize = 0; rdAHigh = 0; rdBIdx = 0; rdBSize = 0; rdBHigh = 0;
    segWrEn = 0; segWrIdx = 0; segWrSrc = 0; segRdIdx = 0;
    ptrWrEn = 0; ptrWrIdx = 0; ptrWrData = 0; ptrRdIdx = 0;
    ipLoad = 0; ipNext = 0;
    tReset(); tFull(); tDword(); tHalf(); tLow(); tHigh();
    tIllegal(); tPorts(); tSeg(); tPtr(); tIp();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule